// File: doc/BRIEF.md
# General-Purpose I/O Bank with Atomic Set and Clear

This block is one bank of 32 general-purpose pins, controlled through a small register bus. Software gives each pin a direction and changes the output levels only through two write-only ports. A write to the set port raises the selected pins. A write to the clear port lowers the selected pins. Neither port needs a read-modify-write sequence, so two agents can change different pins of the same bank without a lock.

The bank's output latch always drives the pad output vector. The direction register decides, pin by pin, whether the output enable is asserted. Because of this, a level can be loaded into the latch while a pin is still an input, and the pin then starts at that level when it becomes an output. The pad levels are brought into the bank's clock domain through a synchronizer chain. Reads of the input register therefore show the real pad state, including pins that the bank drives itself, but only a few cycles after the pad changes.

The request interface has no back-pressure: a request with `bus_valid` high is accepted on every rising edge. A read returns exactly one response, one cycle later, with `rd_valid` high. A write returns no response. `NUM_PINS` sets how many of the 32 bit positions are real pins.

Top module: `gpio_bank`

## Requirements
- R1: Word address 0 holds the direction register. A bit of 1 makes the pin an input (`pad_oe` bit 0). A bit of 0 makes it an output (`pad_oe` bit 1). A write changes `pad_oe` at the edge that accepts it.
- R2: After reset, every valid pin is an input, so the direction register reads as all valid bits set. The output latch is 0, and both `pad_oe` and `pad_out` are 0.
- R3: A write to word address 2 (set port) raises every `pad_out` bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R4: A write to word address 3 (clear port) lowers every `pad_out` bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R5: `pad_out` always follows the output latch, whatever the direction. Only the set and clear ports change the latch. Writes to address 1, changes of direction, and reads leave `pad_out` unchanged.
- R6: Word address 4 returns the synchronized pad input level of every valid pin, including pins that are outputs. A pad change made just before a rising edge is not returned by reads accepted at that edge or the next one. It is returned by a read accepted at the third edge.
- R7: A read of address 1 returns the output latch. Reads of addresses 2, 3, 5, 6 and 7 return 0.
- R8: Bit positions at or above `NUM_PINS` read as 0 in every register. They hold `pad_out` and `pad_oe` at 0, whatever is written.
- R9: A read accepted at one edge sets `rd_valid` high for exactly the following cycle, with `rd_data` valid. An accepted write, or a cycle with no request, leaves `rd_valid` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present; always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data or pin mask |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| pad_in | input | 32 | Levels seen at the pads |
| pad_out | output | 32 | Output latch driven toward the pads |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
On every cycle, the assertions check the following:
- the set and clear ports change exactly the masked bits and leave all others alone;
- `pad_out` stays stable when no set or clear write occurs;
- a direction write shows up on `pad_oe` at the next cycle;
- unused bit positions stay at zero;
- `rd_valid` pairs one-to-one with accepted reads.

Only the bench scenarios can show the following:
- the reset contents;
- the read-back of each address;
- preloading a level before a pin becomes an output;
- the exact edge at which a pad change becomes visible through the synchronizer.

The bench uses a loopback, so the pins that are outputs are read back through the input register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BANK_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR = 3'd0,
    SEL_LAT = 3'd1,
    SEL_SET = 3'd2,
    SEL_CLR = 3'd3,
    SEL_PIN = 3'd4
  } reg_sel_e;

  function automatic logic [BANK_W-1:0] pin_mask(input int n);
    logic [BANK_W-1:0] m;
    for (int i = 0; i < BANK_W; i++) m[i] = (i < n);
    return m;
  endfunction

endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter logic [BANK_W-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] lat_q
);

  logic [BANK_W-1:0] mask_w;
  assign mask_w = wdata & VALID;

  // Direction: 1 = input; reset makes every valid pin an input
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= VALID;
    end else if (wr_en && addr == SEL_DIR) begin
      dir_q <= mask_w;
    end
  end

  // Output latch changes only via the set / clear ports
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (wr_en) begin
      case (addr)
        SEL_SET: lat_q <= lat_q | mask_w;
        SEL_CLR: lat_q <= lat_q & ~mask_w;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_bank_pkg::*;
#(
  parameter int STAGES = 2,
  parameter logic [BANK_W-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] pad_in,
  output logic [BANK_W-1:0] sync_q
);

  logic [BANK_W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= pad_in & VALID;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_q = chain[STAGES-1];

endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] dir_q,
  input  logic [BANK_W-1:0] lat_q,
  input  logic [BANK_W-1:0] pin_q,
  output logic              rd_valid,
  output logic [BANK_W-1:0] rd_data
);

  logic [BANK_W-1:0] sel_data;

  always_comb begin
    case (addr)
      SEL_DIR: sel_data = dir_q;
      SEL_LAT: sel_data = lat_q;
      SEL_PIN: sel_data = pin_q;
      default: sel_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel_data;
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [BANK_W-1:0] rd_data,
  input  logic [BANK_W-1:0] pad_in,
  output logic [BANK_W-1:0] pad_out,
  output logic [BANK_W-1:0] pad_oe
);

  localparam logic [BANK_W-1:0] VALID = pin_mask(NUM_PINS);

  logic [BANK_W-1:0] dir_q, lat_q, pin_q;
  logic              wr_en, rd_en;

  assign wr_en = bus_valid &  bus_write;
  assign rd_en = bus_valid & ~bus_write;

  gpio_ctrl_regs #(.VALID(VALID)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .dir_q (dir_q),
    .lat_q (lat_q)
  );

  gpio_in_sync #(.STAGES(SYNC_STAGES), .VALID(VALID)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .sync_q (pin_q)
  );

  gpio_read_port u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .addr     (bus_addr),
    .dir_q    (dir_q),
    .lat_q    (lat_q),
    .pin_q    (pin_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign pad_out = lat_q;
  assign pad_oe  = ~dir_q & VALID;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BANK_W-1:0] bus_wdata,
  input logic              rd_valid,
  input logic [BANK_W-1:0] rd_data,
  input logic [BANK_W-1:0] pad_out,
  input logic [BANK_W-1:0] pad_oe
);

  localparam logic [BANK_W-1:0] VALID = pin_mask(NUM_PINS);

  logic set_wr, clr_wr, dir_wr, rd_req;
  assign set_wr = bus_valid && bus_write && bus_addr == SEL_SET;
  assign clr_wr = bus_valid && bus_write && bus_addr == SEL_CLR;
  assign dir_wr = bus_valid && bus_write && bus_addr == SEL_DIR;
  assign rd_req = bus_valid && !bus_write;

  // R1
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> pad_oe == (~$past(bus_wdata) & VALID));

  // R3
  set_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> (pad_out & $past(bus_wdata) & VALID) == ($past(bus_wdata) & VALID));

  // R3
  set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> (pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata)));

  // R4
  clr_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (pad_out & $past(bus_wdata)) == '0);

  // R4
  clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata)));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_wr || clr_wr) |=> $stable(pad_out));

  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out | pad_oe | rd_data) & ~VALID) == '0);

  // R9
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R9
  no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
  import gpio_bank_pkg::*;

  localparam int NPINS = 24;
  localparam logic [31:0] MASK = 32'h00FF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic [31:0] ext = '0;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  // loopback: driven pins read back their own level
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_bank #(.NUM_PINS(NPINS), .SYNC_STAGES(2)) dut (
    .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
    .rd_valid, .rd_data, .pad_in, .pad_out, .pad_oe
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk("R9 unexpected response", {31'd0, rd_valid}, 32'd0);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 oe after reset", pad_oe, 32'h0);
    chk("R2 out after reset", pad_out, 32'h0);
    chk("R9 idle rd_valid", {31'd0, rd_valid}, 32'd0);
    rd(3'd0, MASK, "R2 dir after reset");
    rd(3'd1, 32'h0, "R2 latch after reset");

    // R5: preload while the pins are still inputs
    wr(3'd2, 32'h0000_00F0);
    chk("R5 preload out", pad_out, 32'h0000_00F0);
    chk("R5 preload oe", pad_oe, 32'h0);
    chk("R9 no resp to write", {31'd0, rd_valid}, 32'd0);
    wr(3'd0, 32'h00FF_FF00);
    chk("R1 oe after dir write", pad_oe, 32'h0000_00FF);
    chk("R5 out kept on dir change", pad_out, 32'h0000_00F0);
    wr(3'd1, 32'hFFFF_FFFF);
    chk("R5 addr1 write ignored", pad_out, 32'h0000_00F0);

    wr(3'd2, 32'h0000_0003);
    chk("R3 set bits", pad_out, 32'h0000_00F3);
    wr(3'd3, 32'h0000_0030);
    chk("R4 clear bits", pad_out, 32'h0000_00C3);
    wr(3'd2, 32'hFFFF_FFFF);
    chk("R8 set all, upper stay 0", pad_out, MASK);
    rd(3'd1, MASK, "R7 latch readback");
    wr(3'd3, 32'hFFFF_0000);
    chk("R4 clear upper half", pad_out, 32'h0000_FFFF);
    wr(3'd0, 32'hFFFF_FF00);
    chk("R8 oe upper zero", pad_oe, 32'h0000_00FF);
    rd(3'd0, 32'h00FF_FF00, "R1 dir readback");
    rd(3'd2, 32'h0, "R7 set port reads 0");
    rd(3'd3, 32'h0, "R7 clear port reads 0");
    rd(3'd7, 32'h0, "R7 unmapped reads 0");

    // R6: pins 0-7 are outputs at 1; inputs follow ext
    ext = 32'hFF00_0000;
    repeat (4) @(negedge clk);
    rd(3'd4, 32'h0000_00FF, "R6 pin readback incl outputs");
    ext = 32'hFF0A_0000;
    rd(3'd4, 32'h0000_00FF, "R6 sync edge 1 old");
    rd(3'd4, 32'h0000_00FF, "R6 sync edge 2 old");
    rd(3'd4, 32'h000A_00FF, "R6 sync edge 3 new");
    wr(3'd3, 32'h0000_0001);
    repeat (3) @(negedge clk);
    rd(3'd4, 32'h000A_00FE, "R6 output pin level read back");

    repeat (3) @(negedge clk);
    chk("R9 all reads answered", exp_q.size(), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule